// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running time of day for a network clock running at 125 MHz. Each clock period it adds a fixed step of 8 ns to a 40-bit nanosecond count. A 32-bit sub-nanosecond accumulator sits below that count. Software can trim the rate with a signed per-tick correction in units of 2^-32 ns. When the accumulator carries, that tick's step becomes 9 ns. When it borrows, the step becomes 7 ns.

Software reaches the counter through a word-addressed register port. Reading the fraction word takes a snapshot of the nanosecond count, so the two nanosecond words that follow agree with it. Writes are staged in the same way and commit together when the top word is written. A halt bit in the auxiliary control word freezes the timer. The halt bit is set after reset.

Top module: `tod_counter`

## Requirements
- R1: After reset the nanosecond count, the fraction and the adjust word are zero. The auxiliary word reads 0x8000_0000, meaning the timer is halted. Only bit 31 of the auxiliary word is stored; its other bits read zero.
- R2: While running with an adjust word of zero, the nanosecond count grows by exactly 8 every clock.
- R3: An adjust word with bit 31 = 0 adds bits 30:0 to the fraction every tick, modulo 2^32. A carry out of the fraction makes that tick's step 9 ns.
- R4: An adjust word with bit 31 = 1 subtracts bits 30:0 from the fraction every tick, modulo 2^32. A borrow makes that tick's step 7 ns.
- R5: The nanosecond count wraps modulo 2^40.
- R6: While auxiliary bit 31 is 1, the count and the fraction do not change. Writing the bit to 0 resumes counting on the following clock.
- R7: The address map is 0 = fraction, 1 = ns[31:0], 2 = ns[39:32] in bits 7:0, 3 = adjust, 4 = auxiliary. A read of address 0 returns the live fraction and snapshots the count. Addresses 1 and 2 return that snapshot until the next read of address 0. Bits 31:8 of address 2 read zero.
- R8: Writes to addresses 0 and 1 are staged and change nothing by themselves. A write to address 2 loads the count from {data[7:0], staged word 1} and the fraction from staged word 0. On that clock the load replaces the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ns_count | output | 40 | Live nanosecond count |

## Verification
The assertions assume that a write and a read never go to the same address in the same clock. They also assume that only addresses 0 to 4 are used. The stepping checks assume the adjust word changes only while the timer is halted. The bench keeps to these assumptions by issuing one bus operation per clock at the falling edge. It also programs the adjust, fraction and count only while the halt bit is set. The exception is one deliberate write to the time words while the counter runs, which exercises the load-over-increment rule.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_FRAC = 3'd0,
    A_NSLO = 3'd1,
    A_NSHI = 3'd2,
    A_ADJ  = 3'd3,
    A_AUX  = 3'd4
  } tod_addr_e;
endpackage

// File: rtl/tod_frac_accum.sv
module tod_frac_accum #(
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8,
  parameter int STEP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [FRAC_W-1:0] load_frac,
  input  logic              adj_sign,
  input  logic [FRAC_W-2:0] adj_mag,
  output logic [FRAC_W-1:0] frac_q,
  output logic [STEP_W-1:0] step_ns
);
  logic [FRAC_W:0]   sum_ext;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    if (adj_sign) sum_ext = {1'b0, frac_q} - {2'b00, adj_mag};
    else          sum_ext = {1'b0, frac_q} + {2'b00, adj_mag};
    // Bit FRAC_W is a carry when adding and a borrow when subtracting.
    if (!sum_ext[FRAC_W])  step_ns = STEP_W'(STEP_NS);
    else if (adj_sign)     step_ns = STEP_W'(STEP_NS - 1);
    else                   step_ns = STEP_W'(STEP_NS + 1);
    if (load)      frac_d = load_frac;
    else if (run)  frac_d = sum_ext[FRAC_W-1:0];
    else           frac_d = frac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  assert_frac_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !adj_sign) |=> frac_q == $past(frac_q) + FRAC_W'($past(adj_mag)));
  assert_frac_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && adj_sign) |=> frac_q == $past(frac_q) - FRAC_W'($past(adj_mag)));
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8,
  parameter int STEP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [STEP_W-1:0] step_ns,
  output logic [NS_W-1:0]   ns_q
);
  logic [NS_W-1:0] ns_d;

  always_comb begin
    if (load)     ns_d = load_ns;
    else if (run) ns_d = ns_q + NS_W'(step_ns);
    else          ns_d = ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ns_q <= '0;
    else        ns_q <= ns_d;
  end

  assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> ((ns_q - $past(ns_q)) == NS_W'(STEP_NS - 1) ||
                        (ns_q - $past(ns_q)) == NS_W'(STEP_NS)     ||
                        (ns_q - $past(ns_q)) == NS_W'(STEP_NS + 1)));
  assert_hold_when_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(ns_q));
  assert_commit_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ns_q == $past(load_ns));
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int NS_W   = 40,
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NS_W-1:0]       ns_live,
  input  logic [FRAC_W-1:0]     frac_live,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  run,
  output logic                  load,
  output logic [NS_W-1:0]       load_ns,
  output logic [FRAC_W-1:0]     load_frac,
  output logic                  adj_sign,
  output logic [FRAC_W-2:0]     adj_mag
);
  localparam int HI_W = NS_W - DATA_W;

  logic [NS_W-1:0]   shadow_q;
  logic [DATA_W-1:0] stage_lo_q;
  logic [FRAC_W-1:0] stage_frac_q;
  logic [FRAC_W-1:0] adj_q;
  logic              halt_q;

  logic snap_en, st_frac_en, st_lo_en, adj_en, aux_en;

  always_comb begin
    snap_en    = rd_en && (addr == A_FRAC);
    st_frac_en = wr_en && (addr == A_FRAC);
    st_lo_en   = wr_en && (addr == A_NSLO);
    load       = wr_en && (addr == A_NSHI);
    adj_en     = wr_en && (addr == A_ADJ);
    aux_en     = wr_en && (addr == A_AUX);
    load_ns    = {wr_data[HI_W-1:0], stage_lo_q};
    load_frac  = stage_frac_q;
    run        = !halt_q;
    adj_sign   = adj_q[FRAC_W-1];
    adj_mag    = adj_q[FRAC_W-2:0];
    case (addr)
      A_FRAC:  rd_data = frac_live;
      A_NSLO:  rd_data = shadow_q[DATA_W-1:0];
      A_NSHI:  rd_data = {{(DATA_W-HI_W){1'b0}}, shadow_q[NS_W-1:DATA_W]};
      A_ADJ:   rd_data = adj_q;
      A_AUX:   rd_data = {halt_q, {(DATA_W-1){1'b0}}};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q     <= '0;
      stage_lo_q   <= '0;
      stage_frac_q <= '0;
      adj_q        <= '0;
      halt_q       <= 1'b1;
    end else begin
      if (snap_en)    shadow_q     <= ns_live;
      if (st_lo_en)   stage_lo_q   <= wr_data;
      if (st_frac_en) stage_frac_q <= wr_data;
      if (adj_en)     adj_q        <= wr_data;
      if (aux_en)     halt_q       <= wr_data[DATA_W-1];
    end
  end

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(shadow_q));
  assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> shadow_q == $past(ns_live));
  assert_stage_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_NSHI) |-> !load);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NS_W-1:0]       ns_count
);
  localparam int STEP_W = $clog2(STEP_NS + 2);

  logic              run, load, adj_sign;
  logic [NS_W-1:0]   load_ns, ns_q;
  logic [FRAC_W-1:0] load_frac, frac_q;
  logic [FRAC_W-2:0] adj_mag;
  logic [STEP_W-1:0] step_ns;

  tod_regs #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .ns_live(ns_q), .frac_live(frac_q), .rd_data(rd_data),
    .run(run), .load(load), .load_ns(load_ns), .load_frac(load_frac),
    .adj_sign(adj_sign), .adj_mag(adj_mag)
  );

  tod_frac_accum #(.FRAC_W(FRAC_W), .STEP_NS(STEP_NS), .STEP_W(STEP_W)) frac_i (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_frac(load_frac),
    .adj_sign(adj_sign), .adj_mag(adj_mag), .frac_q(frac_q), .step_ns(step_ns)
  );

  tod_ns_counter #(.NS_W(NS_W), .STEP_NS(STEP_NS), .STEP_W(STEP_W)) ns_i (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_ns(load_ns),
    .step_ns(step_ns), .ns_q(ns_q)
  );

  assign ns_count = ns_q;

  assert_halt_freezes_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(frac_q));
endmodule

// File: tb/tod_counter_tb.sv
module tod_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [39:0] ns_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ns_count(ns_count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Each bus task starts at a falling edge and returns one cycle later.
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic snapshot(output logic [39:0] ns, output logic [31:0] fr);
    logic [31:0] lo, hi;
    bus_read(3'd0, fr);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    check("R7 hi reserved", {40'd0, hi[31:8]}, 64'd0);
    ns = {hi[7:0], lo};
  endtask

  task automatic load_time(input logic [39:0] ns, input logic [31:0] fr);
    bus_write(3'd0, fr);
    bus_write(3'd1, ns[31:0]);
    bus_write(3'd2, {24'd0, ns[39:32]});
  endtask

  task automatic t_reset;
    logic [31:0] d, f; logic [39:0] n;
    bus_read(3'd3, d); check("R1 adjust", d, 0);
    bus_read(3'd4, d); check("R1 aux", d, 32'h8000_0000);
    snapshot(n, f);
    check("R1 ns", n, 0); check("R1 frac", f, 0);
    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_read(3'd4, d); check("R1 aux other bits", d, 32'h8000_0000);
  endtask

  task automatic t_nominal;
    logic [31:0] f1, f2; logic [39:0] n1, n2;
    bus_write(3'd3, 32'd0);
    load_time(40'h100, 32'd0);
    bus_write(3'd4, 32'd0);
    snapshot(n1, f1); snapshot(n2, f2);
    check("R2 first", n1, 40'h100);
    check("R2 after 3 ticks", n2, 40'h118);
    check("R2 frac", f2, 0);
  endtask

  task automatic t_positive;
    logic [31:0] f, d; logic [39:0] n1, n2, n3;
    bus_write(3'd4, 32'h8000_0000);
    bus_write(3'd3, 32'h4000_0000);
    bus_read(3'd3, d); check("R3 adjust readback", d, 32'h4000_0000);
    load_time(40'h1000, 32'hC000_0000);
    bus_write(3'd4, 32'd0);
    snapshot(n1, f); check("R3 start", n1, 40'h1000);
    snapshot(n2, f); check("R3 carry step", n2, 40'h1000 + 25);
    check("R3 frac", f, 32'h8000_0000);
    @(negedge clk);
    snapshot(n3, f); check("R3 four ticks", n3, 40'h1000 + 58);
    check("R3 frac wrap", f, 32'h8000_0000);
  endtask

  task automatic t_negative;
    logic [31:0] f; logic [39:0] n1, n2;
    bus_write(3'd4, 32'h8000_0000);
    bus_write(3'd3, 32'hC000_0000);
    load_time(40'h2000, 32'h4000_0000);
    bus_write(3'd4, 32'd0);
    snapshot(n1, f); check("R4 start", n1, 40'h2000);
    snapshot(n2, f); check("R4 borrow step", n2, 40'h2000 + 23);
    check("R4 frac", f, 32'h8000_0000);
  endtask

  task automatic t_halt;
    logic [31:0] f1, f2; logic [39:0] n1, n2;
    bus_write(3'd4, 32'h8000_0000);
    snapshot(n1, f1);
    repeat (5) @(negedge clk);
    snapshot(n2, f2);
    check("R6 ns frozen", n2, n1); check("R6 frac frozen", f2, f1);
    check("R6 port frozen", ns_count, n1);
  endtask

  task automatic t_wrap;
    logic [31:0] f; logic [39:0] n1, n2;
    bus_write(3'd3, 32'd0);
    load_time(40'hFF_FFFF_FFF0, 32'd0);
    bus_write(3'd4, 32'd0);
    snapshot(n1, f); check("R5 before", n1, 40'hFF_FFFF_FFF0);
    snapshot(n2, f); check("R5 wrapped", n2, 40'h8);
  endtask

  task automatic t_latch;
    logic [31:0] f, d; logic [39:0] n;
    bus_write(3'd4, 32'h8000_0000);
    load_time(40'h12_3456_7890, 32'h5);
    snapshot(n, f);
    check("R8 loaded ns", n, 40'h12_3456_7890); check("R8 loaded frac", f, 32'h5);
    bus_write(3'd0, 32'hAAAA);
    bus_write(3'd1, 32'hBBBB);
    snapshot(n, f);
    check("R8 staged ns no effect", n, 40'h12_3456_7890);
    check("R8 staged frac no effect", f, 32'h5);
    bus_write(3'd2, 32'hFFFF_FF01);
    snapshot(n, f);
    check("R8 commit ns", n, 40'h01_0000_BBBB); check("R8 commit frac", f, 32'hAAAA);
    // Load while running: it replaces that clock's increment.
    bus_write(3'd4, 32'd0);
    load_time(40'h3_0000_0500, 32'h7);
    snapshot(n, f);
    check("R8 running load ns", n, 40'h3_0000_0500); check("R8 running load frac", f, 32'h7);
    // R7: the shadow holds while the count moves.
    repeat (5) @(negedge clk);
    bus_read(3'd1, d);
    check("R7 shadow holds", d, 32'h0000_0500);
    check("R7 live moved", ns_count == 40'h3_0000_0500 ? 64'd1 : 64'd0, 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("  CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 port ns", ns_count, 0);
    t_reset();
    t_nominal();
    t_positive();
    t_negative();
    t_halt();
    t_wrap();
    t_latch();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule